// File: doc/BRIEF.md
# Power LED Blink Pattern Generator

This block can take over one pin of a two-port general-purpose I/O bank and drive a power-indicator pattern onto it. An eight-bit configuration word, written through a simple write strobe, holds the enable, a three-bit rate code, a port select and a pin index. From these the block produces, for each port, an override mask and an override value. The I/O bank uses them in place of its own output and direction settings: where a mask bit is set, the pin shows the override value, and that pin's normal input or output role no longer matters.

The pattern is a steady level or a square wave with 50% duty at 1 Hz, 1/2 Hz or 1/4 Hz. All three rates come from one free-running divider that makes a 2 Hz tick from the system clock, whose frequency is a parameter. When a write changes the rate code, the blink phase restarts, so the new rate always begins with a full high half-period.

Top module: `pwr_led_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the configuration word is 0x00 and every override mask and value bit on both ports is 0.
- R2: With the enable (configuration bit 7) at 0, both override masks are all zero whatever the other fields hold.
- R3: With enable set and port select (bit 3) at 0, the port-1 mask has exactly the bit given by the pin index (bits 2..0) set for indices 0 to 6. Index 7 gives no override, and the port-2 mask stays zero.
- R4: With enable set and port select at 1, the port-2 mask has exactly the indexed bit set for indices 3, 4 and 5. Any other index gives no override, and the port-1 mask stays zero.
- R5: Rate code 3'b111 (bits 6..4) makes the override value 1 on the selected pin, which releases an open-drain pad.
- R6: Rate codes 3'b000, 3'b001, 3'b010 and 3'b011 make the override value 0 on the selected pin.
- R7: Rate code 3'b110 gives a square wave that starts high and changes level every CLK_HZ/2 clock cycles (1 Hz).
- R8: Rate code 3'b101 changes level every CLK_HZ cycles (1/2 Hz), and 3'b100 every 2*CLK_HZ cycles (1/4 Hz). Both start high.
- R9: A write that changes the rate field restarts the phase. From the cycle after that write edge, a blinking rate shows a full high half-period.
- R10: At most one mask bit is set across both ports, and no override value bit is 1 where its mask bit is 0.
- R11: A write that leaves the rate field unchanged (for example a new pin index) does not disturb the blink phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ Hz |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration word: bit 7 enable, bits 6..4 rate, bit 3 port, bits 2..0 pin index |
| p1_ovr_mask_o | output | P1_PINS | Port-1 per-pin override mask |
| p1_ovr_val_o | output | P1_PINS | Port-1 per-pin override value |
| p2_ovr_mask_o | output | P2_PINS | Port-2 per-pin override mask |
| p2_ovr_val_o | output | P2_PINS | Port-2 per-pin override value |

## Verification
The assertions check on every cycle the properties that do not depend on time:
- no more than one pin is overridden;
- no value bit is 1 outside the mask;
- the masks are empty while the block is disabled;
- the legal pin ranges on each port;
- the steady-level codes;
- a wave starts high after a write that changes the rate.

The timing of the waves can only be shown by the bench's scenarios, which track the phase against cycle counts. That covers half-periods that are exactly CLK_HZ/2, CLK_HZ and 2*CLK_HZ cycles long, the phase restarting on a rate change, and the phase carrying on when a write keeps the same rate.

// File: rtl/pwr_led_pkg.sv
package pwr_led_pkg;

  typedef struct packed {
    logic       en;
    logic [2:0] rate;
    logic       port;
    logic [2:0] idx;
  } led_cfg_t;

  localparam logic [2:0] RATE_RELEASE = 3'b111;
  localparam logic [2:0] RATE_1HZ     = 3'b110;
  localparam logic [2:0] RATE_HALFHZ  = 3'b101;
  localparam logic [2:0] RATE_QTRHZ   = 3'b100;

  localparam int PHASE_W = 3;

endpackage

// File: rtl/led_tick_div.sv
// Free-running divider: one phase step every TICK_CYC cycles (2 Hz),
// restartable so a new rate begins at the start of its high half.
module led_tick_div #(
  parameter int TICK_CYC = 20,
  parameter int PH_W     = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  output logic [PH_W-1:0] phase_o
);
  localparam int CNT_W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             tick;

  assign tick = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (restart_i) begin
      cnt_d = '0;
      ph_d  = '0;
    end else if (tick) begin
      cnt_d = '0;
      ph_d  = ph_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/led_wave_sel.sv
// Maps the rate code and phase count onto the pattern level.
module led_wave_sel
  import pwr_led_pkg::*;
(
  input  logic [2:0]         rate_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               lvl_o
);
  always_comb begin
    unique case (rate_i)
      RATE_RELEASE: lvl_o = 1'b1;
      RATE_1HZ:     lvl_o = ~phase_i[0];
      RATE_HALFHZ:  lvl_o = ~phase_i[1];
      RATE_QTRHZ:   lvl_o = ~phase_i[2];
      default:      lvl_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/led_pin_route.sv
// Drives the override onto one port; only indices in the legal range decode.
module led_pin_route #(
  parameter int   N_PINS  = 8,
  parameter int   IDX_MIN = 0,
  parameter int   IDX_MAX = 6,
  parameter logic PORT_ID = 1'b0
) (
  input  logic              en_i,
  input  logic              port_i,
  input  logic [2:0]        idx_i,
  input  logic              lvl_i,
  output logic [N_PINS-1:0] mask_o,
  output logic [N_PINS-1:0] val_o
);
  logic port_hit;
  assign port_hit = en_i && (port_i == PORT_ID);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    if (i >= IDX_MIN && i <= IDX_MAX) begin : g_legal
      assign mask_o[i] = port_hit && (idx_i == 3'(i));
    end else begin : g_never
      assign mask_o[i] = 1'b0;
    end
    assign val_o[i] = mask_o[i] & lvl_i;
  end
endmodule

// File: rtl/pwr_led_ctrl.sv
module pwr_led_ctrl
  import pwr_led_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int P1_PINS    = 8,
  parameter int P2_PINS    = 7,
  parameter int P1_IDX_MIN = 0,
  parameter int P1_IDX_MAX = 6,
  parameter int P2_IDX_MIN = 3,
  parameter int P2_IDX_MAX = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [7:0]         cfg_wdata_i,
  output logic [P1_PINS-1:0] p1_ovr_mask_o,
  output logic [P1_PINS-1:0] p1_ovr_val_o,
  output logic [P2_PINS-1:0] p2_ovr_mask_o,
  output logic [P2_PINS-1:0] p2_ovr_val_o
);
  localparam int TICK_CYC = CLK_HZ / 2;

  logic [1:0]         rst_sync_q;
  logic               rst_n;
  led_cfg_t           cfg_q, cfg_d, cfg_wr;
  logic               restart;
  logic [PHASE_W-1:0] phase;
  logic               wave_lvl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign cfg_wr  = led_cfg_t'(cfg_wdata_i);
  assign restart = cfg_we_i && (cfg_wr.rate != cfg_q.rate);

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we_i) cfg_d = cfg_wr;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  led_tick_div #(.TICK_CYC(TICK_CYC), .PH_W(PHASE_W)) div_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .restart_i (restart),
    .phase_o   (phase)
  );

  led_wave_sel wave_i (
    .rate_i  (cfg_q.rate),
    .phase_i (phase),
    .lvl_o   (wave_lvl)
  );

  led_pin_route #(.N_PINS(P1_PINS), .IDX_MIN(P1_IDX_MIN), .IDX_MAX(P1_IDX_MAX),
                  .PORT_ID(1'b0)) route_p1_i (
    .en_i   (cfg_q.en),
    .port_i (cfg_q.port),
    .idx_i  (cfg_q.idx),
    .lvl_i  (wave_lvl),
    .mask_o (p1_ovr_mask_o),
    .val_o  (p1_ovr_val_o)
  );

  led_pin_route #(.N_PINS(P2_PINS), .IDX_MIN(P2_IDX_MIN), .IDX_MAX(P2_IDX_MAX),
                  .PORT_ID(1'b1)) route_p2_i (
    .en_i   (cfg_q.en),
    .port_i (cfg_q.port),
    .idx_i  (cfg_q.idx),
    .lvl_i  (wave_lvl),
    .mask_o (p2_ovr_mask_o),
    .val_o  (p2_ovr_val_o)
  );
endmodule

// File: rtl/pwr_led_ctrl_chk.sv
module pwr_led_ctrl_chk #(
  parameter int P1_PINS    = 8,
  parameter int P2_PINS    = 7,
  parameter int P1_IDX_MIN = 0,
  parameter int P1_IDX_MAX = 6,
  parameter int P2_IDX_MIN = 3,
  parameter int P2_IDX_MAX = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [7:0]         cfg_wdata_i,
  input logic [7:0]         cfg_q_i,
  input logic               wave_i,
  input logic [P1_PINS-1:0] p1_mask_i,
  input logic [P1_PINS-1:0] p1_val_i,
  input logic [P2_PINS-1:0] p2_mask_i,
  input logic [P2_PINS-1:0] p2_val_i
);
  function automatic logic [P1_PINS-1:0] p1_legal();
    logic [P1_PINS-1:0] m = '0;
    for (int i = 0; i < P1_PINS; i++) m[i] = (i >= P1_IDX_MIN && i <= P1_IDX_MAX);
    return m;
  endfunction

  function automatic logic [P2_PINS-1:0] p2_legal();
    logic [P2_PINS-1:0] m = '0;
    for (int i = 0; i < P2_PINS; i++) m[i] = (i >= P2_IDX_MIN && i <= P2_IDX_MAX);
    return m;
  endfunction

  localparam logic [P1_PINS-1:0] P1_OK = p1_legal();
  localparam logic [P2_PINS-1:0] P2_OK = p2_legal();

  a_r10_single_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({p2_mask_i, p1_mask_i}));

  a_r10_val_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((p1_val_i & ~p1_mask_i) == '0) && ((p2_val_i & ~p2_mask_i) == '0));

  a_r2_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q_i[7] |-> (p1_mask_i == '0 && p2_mask_i == '0));

  a_r3_p1_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_mask_i & ~P1_OK) == '0);

  a_r4_p2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_mask_i & ~P2_OK) == '0);

  a_r5_released_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q_i[6:4] == 3'b111) |-> (p1_val_i == p1_mask_i && p2_val_i == p2_mask_i));

  a_r6_driven_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q_i[6] |-> (p1_val_i == '0 && p2_val_i == '0));

  a_r9_restart_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[6:4] != cfg_q_i[6:4] && cfg_wdata_i[6]
     && cfg_wdata_i[6:4] != 3'b111) |=> wave_i);
endmodule

bind pwr_led_ctrl pwr_led_ctrl_chk #(
  .P1_PINS(P1_PINS), .P2_PINS(P2_PINS),
  .P1_IDX_MIN(P1_IDX_MIN), .P1_IDX_MAX(P1_IDX_MAX),
  .P2_IDX_MIN(P2_IDX_MIN), .P2_IDX_MAX(P2_IDX_MAX)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_n),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_q_i     (cfg_q),
  .wave_i      (wave_lvl),
  .p1_mask_i   (p1_ovr_mask_o),
  .p1_val_i    (p1_ovr_val_o),
  .p2_mask_i   (p2_ovr_mask_o),
  .p2_val_i    (p2_ovr_val_o)
);

// File: tb/pwr_led_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_led_ctrl_tb_top;
  localparam int CLK_HZ = 40;
  localparam int T      = CLK_HZ / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] p1m, p1v;
  logic [6:0] p2m, p2v;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int restart_cyc = 0;
  logic [7:0] model_cfg = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_led_ctrl #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .p1_ovr_mask_o(p1m), .p1_ovr_val_o(p1v),
    .p2_ovr_mask_o(p2m), .p2_ovr_val_o(p2v)
  );

  function automatic logic exp_level(logic [2:0] rate, int n);
    case (rate)
      3'b111:  return 1'b1;
      3'b110:  return ((n / T) % 2) == 0;
      3'b101:  return ((n / (2 * T)) % 2) == 0;
      3'b100:  return ((n / (4 * T)) % 2) == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_p1(logic [7:0] c);
    if (c[7] && !c[3] && c[2:0] <= 3'd6) return 8'(1) << c[2:0];
    return '0;
  endfunction

  function automatic logic [6:0] exp_p2(logic [7:0] c);
    if (c[7] && c[3] && c[2:0] >= 3'd3 && c[2:0] <= 3'd5) return 7'(1) << c[2:0];
    return '0;
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h cyc=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    we = 1'b1;
    wdata = v;
    @(posedge clk);
    #1;
    if (v[6:4] != model_cfg[6:4]) restart_cyc = cyc;
    model_cfg = v;
    we = 1'b0;
  endtask

  task automatic step_check(string mtag = "", string vtag = "");
    logic [7:0] em1;
    logic [6:0] em2;
    logic       lvl;
    string      mt, vt;
    @(negedge clk);
    em1 = exp_p1(model_cfg);
    em2 = exp_p2(model_cfg);
    lvl = exp_level(model_cfg[6:4], cyc - restart_cyc);
    mt = mtag;
    if (mt == "") mt = !model_cfg[7] ? "R2" : (model_cfg[3] ? "R4" : "R3");
    vt = vtag;
    if (vt == "") begin
      if (model_cfg[6:4] == 3'b111)      vt = "R5";
      else if (!model_cfg[6])            vt = "R6";
      else if (model_cfg[6:4] == 3'b110) vt = "R7";
      else                               vt = "R8";
    end
    check(mt, "p1_mask", {8'h0, p1m}, {8'h0, em1});
    check(mt, "p2_mask", {9'h0, p2m}, {9'h0, em2});
    check(vt, "p1_val", {8'h0, p1v}, {8'h0, (lvl ? em1 : 8'h00)});
    check(vt, "p2_val", {9'h0, p2v}, {9'h0, (lvl ? em2 : 7'h00)});
  endtask

  task automatic run(int k, string mtag = "", string vtag = "");
    for (int i = 0; i < k; i++) step_check(mtag, vtag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    run(4, "R1", "R1");
    @(negedge clk) rst_n = 1'b1;
    run(4, "R1", "R1");

    // R7: 1 Hz wave on port 1 pin 2, across two full periods
    write_cfg(8'hE2);
    run(4 * T + 2);
    // R9: rate change mid-phase restarts with a full high half
    run(7);
    write_cfg(8'hD2);
    run(2 * T + 1, "", "R9");
    run(2 * T + 1);                   // R8 half-rate
    // R11: same rate, new pin keeps the phase
    write_cfg(8'hC2);
    run(30);
    write_cfg(8'hC5);
    run(70, "", "R11");
    run(100);                         // R8 quarter-rate
    // R4/R5: released high on port 2 pin 4
    write_cfg(8'hFC);
    run(3);
    // R6: code 000 and 011 drive low
    write_cfg(8'h8B);
    run(3);
    write_cfg(8'hB0);
    run(3);
    // R4: illegal port-2 indices give no override
    write_cfg(8'hFA);
    run(2, "R4");
    write_cfg(8'hFE);
    run(2, "R4");
    // R3: index 7 on port 1 gives no override
    write_cfg(8'hE7);
    run(2, "R3", "R10");
    // R2: disabled with a blinking rate
    write_cfg(8'h62);
    run(3);

    // random configurations, checked every cycle
    for (int r = 0; r < 60; r++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if (($urandom % 4) != 0) v[7] = 1'b1;
      write_cfg(v);
      run(1 + int'($urandom % 120));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule